// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer arithmetic and logic stage of a small load/store datapath. It takes two 32-bit operands and a 4-bit operation code and produces a 32-bit result combinationally. It also produces a write-enable that tells the register file whether the result should be stored. Sixteen operations are supported: plain, carry-chained and reverse-order add and subtract, bitwise AND, OR, XOR and mask-clear, move and move-inverted, and four compare/test forms that only touch the status flags.

Four status flags are held in a register inside the block: negative, zero, carry and overflow. When the set-flags input is high, the flags are loaded on the rising clock edge. Each such load replaces the earlier flag values, so only the most recent flag-setting operation is visible. The carry-chained operations read the stored carry flag as their carry-in. The shifter, immediate decoding, the register file and the evaluation of condition codes sit outside this block.

Top module: `cc_alu`

## Requirements
- R1: Opcode 4 (add) gives a+b, opcode 5 (add with carry) gives a+b+C, and opcode 11 (compare-add) computes a+b for the flags only. C is the stored carry flag.
- R2: Opcode 2 (subtract) gives a-b, opcode 6 (subtract with carry) gives a-b-(1-C), and opcode 10 (compare) computes a-b for the flags only. For every subtraction, carry is 1 when no borrow occurs.
- R3: Opcode 3 (reverse subtract) gives b-a, and opcode 7 (reverse subtract with carry) gives b-a-(1-C).
- R4: Opcode 0 gives a AND b, opcode 1 gives a XOR b, and opcode 12 gives a OR b. Opcode 8 (test) computes a AND b and opcode 9 (test-equal) computes a XOR b.
- R5: Opcode 14 (mask clear) gives a AND NOT b, so every 1 bit of b clears the matching bit of a.
- R6: Opcode 13 gives b and opcode 15 gives NOT b.
- R7: After a rising edge with set-flags high, negative equals bit 31 of the result and zero is 1 exactly when all 32 result bits are 0.
- R8: After a rising edge with set-flags high on an arithmetic opcode (2 to 7, 10, 11), carry holds the carry out of bit 31 and overflow holds the signed two's-complement overflow.
- R9: Logical opcodes (0, 1, 8, 9, 12 to 15) with set-flags high leave carry and overflow unchanged.
- R10: With set-flags low, all four flags keep their values across the clock edge.
- R11: Write-enable is 0 for opcodes 8 to 11 and 1 for every other opcode.
- R12: While rst_ni is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opa_i | input | 32 | First operand (a) |
| opb_i | input | 32 | Second operand (b) |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Load the flags on the next rising edge |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Result write-enable |
| flag_n_o | output | 1 | Stored negative flag |
| flag_z_o | output | 1 | Stored zero flag |
| flag_c_o | output | 1 | Stored carry flag |
| flag_v_o | output | 1 | Stored overflow flag |

## Verification
The result and the write-enable are combinational, so they are due in the same cycle as the operands. The bench drives inputs at the falling edge and samples these two outputs 1 ns later. The flags pass through a single register, so they change at the first rising edge after the stimulus. The bench reads them at the following falling edge, before it drives the next vector. The reset clear is asynchronous and is sampled shortly after rst_ni falls, with no clock edge in between.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND   = 4'h0,
    OP_XOR   = 4'h1,
    OP_SUB   = 4'h2,
    OP_RSUB  = 4'h3,
    OP_ADD   = 4'h4,
    OP_ADDC  = 4'h5,
    OP_SUBC  = 4'h6,
    OP_RSUBC = 4'h7,
    OP_TAND  = 4'h8,
    OP_TXOR  = 4'h9,
    OP_CSUB  = 4'hA,
    OP_CADD  = 4'hB,
    OP_OR    = 4'hC,
    OP_MOVE  = 4'hD,
    OP_CLR   = 4'hE,
    OP_MOVEN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic op_is_arith(input alu_op_e op);
    unique case (op)
      OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC, OP_RSUBC, OP_CSUB, OP_CADD:
        op_is_arith = 1'b1;
      default: op_is_arith = 1'b0;
    endcase
  endfunction

  function automatic logic op_no_write(input alu_op_e op);
    unique case (op)
      OP_TAND, OP_TXOR, OP_CSUB, OP_CADD: op_no_write = 1'b1;
      default: op_no_write = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cc_alu_addsub.sv
module cc_alu_addsub
  import cc_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             c0;
  logic [WIDTH:0]   full;

  // Operand steering: subtraction is x + ~y + carry-in
  always_comb begin
    x  = a_i;
    y  = b_i;
    c0 = 1'b0;
    unique case (op_i)
      OP_ADD, OP_CADD: begin x = a_i; y = b_i;  c0 = 1'b0;  end
      OP_ADDC:         begin x = a_i; y = b_i;  c0 = cin_i; end
      OP_SUB, OP_CSUB: begin x = a_i; y = ~b_i; c0 = 1'b1;  end
      OP_SUBC:         begin x = a_i; y = ~b_i; c0 = cin_i; end
      OP_RSUB:         begin x = b_i; y = ~a_i; c0 = 1'b1;  end
      OP_RSUBC:        begin x = b_i; y = ~a_i; c0 = cin_i; end
      default:         begin x = a_i; y = b_i;  c0 = 1'b0;  end
    endcase
  end

  assign full   = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, c0};
  assign sum_o  = full[MSB:0];
  assign cout_o = full[WIDTH];
  assign ovf_o  = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
endmodule

// File: rtl/cc_alu_logic.sv
module cc_alu_logic
  import cc_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TAND: res_o = a_i & b_i;
      OP_XOR, OP_TXOR: res_o = a_i ^ b_i;
      OP_OR:           res_o = a_i | b_i;
      OP_MOVE:         res_o = b_i;
      OP_CLR:          res_o = a_i & ~b_i;
      OP_MOVEN:        res_o = ~b_i;
      default:         res_o = '0;
    endcase
  end
endmodule

// File: rtl/cc_alu_flags.sv
module cc_alu_flags
  import cc_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             arith_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             cout_i,
  input  logic             ovf_i,
  output flags_t           flags_o
);
  flags_t nxt;

  always_comb begin
    nxt   = flags_o;
    nxt.n = res_i[WIDTH-1];
    nxt.z = ~|res_i;
    if (arith_i) begin
      nxt.c = cout_i;
      nxt.v = ovf_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_o <= '0;
    else if (upd_i) flags_o <= nxt;
  end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [3:0]       op_i,
  input  logic             set_flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_c_o,
  output logic             flag_v_o
);
  alu_op_e          op;
  logic             arith;
  logic [WIDTH-1:0] sum, lres;
  logic             cout, ovf;
  flags_t           flags;

  assign op    = alu_op_e'(op_i);
  assign arith = op_is_arith(op);

  cc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .op_i  (op),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .cin_i (flags.c),
    .sum_o (sum),
    .cout_o(cout),
    .ovf_o (ovf)
  );

  cc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i (op),
    .a_i  (opa_i),
    .b_i  (opb_i),
    .res_o(lres)
  );

  assign result_o = arith ? sum : lres;
  assign wr_en_o  = ~op_no_write(op);

  cc_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (set_flags_i),
    .arith_i(arith),
    .res_i  (result_o),
    .cout_i (cout),
    .ovf_i  (ovf),
    .flags_o(flags)
  );

  assign flag_n_o = flags.n;
  assign flag_z_o = flags.z;
  assign flag_c_o = flags.c;
  assign flag_v_o = flags.v;
endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [3:0]       op_i,
  input logic             set_flags_i,
  input logic [WIDTH-1:0] result_o,
  input logic             wr_en_o,
  input logic             flag_n_o,
  input logic             flag_z_o,
  input logic             flag_c_o,
  input logic             flag_v_o
);
  logic [3:0] fl;
  assign fl = {flag_n_o, flag_z_o, flag_c_o, flag_v_o};

  assert_cmp_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'h8 && op_i <= 4'hB) |-> !wr_en_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_flags_i |=> $stable(fl));

  assert_neg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flags_i |=> flag_n_o == $past(result_o[WIDTH-1]));

  assert_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flags_i |=> flag_z_o == ($past(result_o) == '0));

  assert_logic_cv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && (op_i < 4'h2 || op_i == 4'h8 || op_i == 4'h9 || op_i >= 4'hC))
    |=> ($stable(flag_c_o) && $stable(flag_v_o)));

  assert_add_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && op_i == 4'h4) |=>
    flag_v_o == (($past(opa_i[WIDTH-1]) == $past(opb_i[WIDTH-1])) &&
                 ($past(result_o[WIDTH-1]) != $past(opa_i[WIDTH-1]))));

  assert_clear_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'hE |-> ((result_o & opb_i) == '0 && (result_o | opb_i) == (opa_i | opb_i)));
endmodule

bind cc_alu cc_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .opa_i      (opa_i),
  .opb_i      (opb_i),
  .op_i       (op_i),
  .set_flags_i(set_flags_i),
  .result_o   (result_o),
  .wr_en_o    (wr_en_o),
  .flag_n_o   (flag_n_o),
  .flag_z_o   (flag_z_o),
  .flag_c_o   (flag_c_o),
  .flag_v_o   (flag_v_o)
);

// File: tb/cc_alu_tb_top.sv
`timescale 1ns/1ps
module cc_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic [3:0]  op_i = '0;
  logic        set_flags_i = 1'b0;
  logic [31:0] result_o;
  logic        wr_en_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  cc_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .opa_i(opa_i), .opb_i(opb_i), .op_i(op_i),
    .set_flags_i(set_flags_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .flag_v_o(flag_v_o)
  );

  // {op, a, b, set_flags, result, wr_en, NZCV after the edge}
  localparam int NV = 22;
  localparam logic [105:0] VEC [NV] = '{
    {4'h4, 32'h00000001, 32'h00000002, 1'b1, 32'h00000003, 1'b1, 4'b0000},
    {4'h4, 32'hFFFFFFFF, 32'h00000001, 1'b1, 32'h00000000, 1'b1, 4'b0110},
    {4'h5, 32'h00000005, 32'h00000006, 1'b1, 32'h0000000C, 1'b1, 4'b0000},
    {4'h4, 32'h7FFFFFFF, 32'h00000001, 1'b1, 32'h80000000, 1'b1, 4'b1001},
    {4'h2, 32'h00000005, 32'h00000003, 1'b1, 32'h00000002, 1'b1, 4'b0010},
    {4'h6, 32'h0000000A, 32'h00000003, 1'b1, 32'h00000007, 1'b1, 4'b0010},
    {4'h2, 32'h00000003, 32'h00000005, 1'b1, 32'hFFFFFFFE, 1'b1, 4'b1000},
    {4'h6, 32'h0000000A, 32'h00000003, 1'b1, 32'h00000006, 1'b1, 4'b0010},
    {4'h3, 32'h00000003, 32'h0000000A, 1'b1, 32'h00000007, 1'b1, 4'b0010},
    {4'hA, 32'h00000000, 32'h00000001, 1'b1, 32'hFFFFFFFF, 1'b0, 4'b1000},
    {4'h7, 32'h00000003, 32'h0000000A, 1'b1, 32'h00000006, 1'b1, 4'b0010},
    {4'h2, 32'h80000000, 32'h00000001, 1'b1, 32'h7FFFFFFF, 1'b1, 4'b0011},
    {4'h0, 32'hF0F0F0F0, 32'h0FF00FF0, 1'b1, 32'h00F000F0, 1'b1, 4'b0011},
    {4'h1, 32'hFFFF0000, 32'h0000FFFF, 1'b1, 32'hFFFFFFFF, 1'b1, 4'b1011},
    {4'h8, 32'h0F0F0F0F, 32'hF0F0F0F0, 1'b1, 32'h00000000, 1'b0, 4'b0111},
    {4'hC, 32'h12340000, 32'h00005678, 1'b0, 32'h12345678, 1'b1, 4'b0111},
    {4'hE, 32'hFFFFFFFF, 32'h0000FF00, 1'b1, 32'hFFFF00FF, 1'b1, 4'b1011},
    {4'hD, 32'h12345678, 32'h00000000, 1'b1, 32'h00000000, 1'b1, 4'b0111},
    {4'hF, 32'h12345678, 32'h00000000, 1'b1, 32'hFFFFFFFF, 1'b1, 4'b1011},
    {4'h9, 32'hAAAA5555, 32'hAAAA5555, 1'b1, 32'h00000000, 1'b0, 4'b0111},
    {4'hB, 32'hFFFFFFFF, 32'h00000001, 1'b1, 32'h00000000, 1'b0, 4'b0110},
    {4'h5, 32'h00000000, 32'h00000000, 1'b0, 32'h00000001, 1'b1, 4'b0110}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h4, 4'h5, 4'hB: req_of = "R1";
      4'h2, 4'h6, 4'hA: req_of = "R2";
      4'h3, 4'h7:       req_of = "R3";
      4'hE:             req_of = "R5";
      4'hD, 4'hF:       req_of = "R6";
      default:          req_of = "R4";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fl();
    return {28'd0, flag_n_o, flag_z_o, flag_c_o, flag_v_o};
  endfunction

  initial begin
    repeat (50000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk("R12", "flags in reset", fl(), 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12", "flags after reset", fl(), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [105:0] v;
      string        fr;
      v           = VEC[i];
      op_i        = v[105:102];
      opa_i       = v[101:70];
      opb_i       = v[69:38];
      set_flags_i = v[37];
      #1;
      chk(req_of(op_i), "result", result_o, v[36:5]);
      chk("R11", "wr_en", {31'd0, wr_en_o}, {31'd0, v[4]});
      @(posedge clk_i);
      @(negedge clk_i);
      if (!v[37])                                         fr = "R10";
      else if (op_i inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF}) fr = "R9";
      else                                                fr = "R8";
      chk(fr, "flags NZCV", fl(), {28'd0, v[3:0]});
      chk("R7", "N/Z flags", {30'd0, flag_n_o, flag_z_o}, {30'd0, v[3:2]});
    end

    // Corner: add with carry chained from a carry produced one step before
    op_i = 4'h4; opa_i = 32'hFFFFFFFF; opb_i = 32'hFFFFFFFF; set_flags_i = 1'b1;
    @(negedge clk_i);
    chk("R8", "carry from all-ones add", fl(), 32'hA); // N=1 Z=0 C=1 V=0
    op_i = 4'h5; opa_i = 32'h7FFFFFFF; opb_i = 32'h00000000;
    #1;
    chk("R1", "add with carry into sign", result_o, 32'h80000000);
    @(negedge clk_i);
    chk("R8", "overflow via carry-in", fl(), 32'h9);

    // Asynchronous reset clears stored flags mid-cycle
    set_flags_i = 1'b0;
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R12", "flags on async reset", fl(), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    op_i = 4'hA; opa_i = 32'h1; opb_i = 32'h1; set_flags_i = 1'b1;
    #1;
    chk("R11", "compare wr_en", {31'd0, wr_en_o}, 32'h0);
    @(negedge clk_i);
    chk("R2", "compare equal flags", fl(), 32'h6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule